// File: doc/BRIEF.md
# Reed-Solomon Decoder Output Monitor

This block watches the corrected output of several Reed-Solomon decoders, each carrying `NCH` byte-interleaved codewords of `N` symbols. For each decoder it builds a write strobe that passes only the information symbols to a downstream FIFO and drops the trailing check symbols. It also turns the decoders' status outputs into link-quality figures. These are a per-decoder latched error count, a saturating running total of corrected symbols, and a sticky failure interrupt.

A decoder reports how many symbols it corrected, but it does not say where they were. To recover the positions, the block compares each decoder's delayed raw input with its corrected output, one symbol at a time. A channel/symbol counter tags every symbol that differs, and the tag goes into a small per-decoder store. The store is rebuilt for each block. It keeps the first `POS_DEPTH` positions and raises an overflow flag when more arrive. Any decoder's store can be read through a combinational select port.

Top module: `rs_err_monitor`

## Requirements
- R1: After reset, all outputs are zero: write strobes, write data, latched counts, running total, interrupt, store fill count and overflow flag.
- R2: A decoder's `fifo_wr` goes high one cycle after the first cycle of its `blk_start`. `fifo_data` carries `dec_data` with the same one-cycle delay.
- R3: `fifo_wr` stays high through the last cycle of `info_end` and drops one cycle after `info_end` falls. Exactly `K*NCH` symbols per block are written, and no check symbol is written.
- R4: In any cycle where at least one `err_found` bit is high, each decoder whose `dec_fail` bit is low latches its `err_cnt` into its `cnt_stat` slice on the next edge. With no `err_found` bit high, the slices hold.
- R5: A decoder whose `dec_fail` bit is high never updates its `cnt_stat` slice and adds nothing to the running total.
- R6: The running total adds the `err_cnt` of every decoder with `err_found` high and `dec_fail` low. It saturates at `2**ACC_W-1`.
- R7: `fail_irq` rises one cycle after any `dec_fail` bit is high. It stays high until a cycle with `irq_clr` high and no `dec_fail` high. A new failure outranks the clear.
- R8: A symbol whose `dec_raw` differs from `dec_data` is recorded, in order of arrival, as a 12-bit entry. Bits [7:0] hold the symbol index and bits [11:8] hold the channel. Check symbols are included.
- R9: The position counter restarts on the first cycle of `blk_start`, including back-to-back blocks. The symbol index is the number of cycles since that cycle divided by `NCH`, and the channel is the remainder.
- R10: The store keeps the first `POS_DEPTH` entries of a block. On a further difference, `rd_ovf` is set and the stored entries stay as they were. The fill count and the overflow flag clear at the next block start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_start | input | NDEC | Per decoder: first corrected symbol, NCH cycles wide |
| info_end | input | NDEC | Per decoder: last information symbol, NCH cycles wide |
| dec_data | input | NDEC*8 | Corrected symbols |
| dec_raw | input | NDEC*8 | Raw decoder input, delayed to align with `dec_data` |
| err_cnt | input | NDEC*5 | Corrected-symbol count per decoder |
| err_found | input | NDEC | One-cycle strobe: the decoder found errors |
| dec_fail | input | NDEC | One-cycle strobe: the block could not be corrected |
| irq_clr | input | 1 | Clears the sticky interrupt |
| rd_dec | input | max(1,clog2(NDEC)) | Decoder whose position store is read |
| rd_idx | input | clog2(POS_DEPTH) | Entry index to read |
| fifo_wr | output | NDEC | FIFO write enable per decoder |
| fifo_data | output | NDEC*8 | FIFO write data per decoder |
| cnt_stat | output | NDEC*5 | Latched error count per decoder |
| total_corr | output | ACC_W | Saturating total of corrected symbols |
| fail_irq | output | 1 | Sticky failure interrupt |
| rd_entry | output | 12 | Selected entry: channel in [11:8], symbol in [7:0] |
| rd_fill | output | clog2(POS_DEPTH+1) | Entries recorded in the current block |
| rd_ovf | output | 1 | More differences than store entries in this block |

## Verification
The assertions rely on three things about the inputs. Each `blk_start` is a contiguous `NCH`-cycle pulse with at least one low cycle before it. Each `info_end` is a contiguous pulse that ends before the next `blk_start`. `err_found` and `dec_fail` are single-cycle strobes. The stimulus meets these conditions by generating every block from one symbol-cycle loop that places both pulses by symbol index, and by sending status strobes only while no block is running. All inputs change on the falling clock edge, so the rising-edge assertions never see a partially updated input.

// File: rtl/rs_mon_pkg.sv
package rs_mon_pkg;

    localparam int SYM_W   = 8;
    localparam int ERR_W   = 5;
    localparam int CH_W    = 4;
    localparam int POS_W   = 8;

    typedef struct packed {
        logic [CH_W-1:0]  ch;
        logic [POS_W-1:0] sym;
    } pos_entry_t;

    localparam int ENTRY_W = $bits(pos_entry_t);

    function automatic logic sym_corrected(input logic [SYM_W-1:0] raw,
                                           input logic [SYM_W-1:0] fixed);
        return |(raw ^ fixed);
    endfunction

endpackage

// File: rtl/rs_mon_lane.sv
module rs_mon_lane
    import rs_mon_pkg::*;
#(
    parameter int unsigned NCH       = 2,
    parameter int unsigned N         = 255,
    parameter int unsigned POS_DEPTH = 16,
    localparam int RD_W   = $clog2(POS_DEPTH),
    localparam int FILL_W = $clog2(POS_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               blk_start,
    input  logic               info_end,
    input  logic [SYM_W-1:0]   dec_data,
    input  logic [SYM_W-1:0]   dec_raw,
    input  logic [RD_W-1:0]    rd_idx,
    output logic               wr_o,
    output logic [SYM_W-1:0]   data_o,
    output pos_entry_t         rd_entry,
    output logic [FILL_W-1:0]  fill_o,
    output logic               ovf_o
);

    // write window
    logic bs_q, ie_q, win_q;
    logic [SYM_W-1:0] data_q;
    logic start, active;

    assign start  = blk_start & ~bs_q;
    assign active = blk_start | (win_q & ~(ie_q & ~info_end));

    always_ff @(posedge clk) begin
        if (rst) begin
            bs_q   <= 1'b0;
            ie_q   <= 1'b0;
            win_q  <= 1'b0;
            data_q <= '0;
        end else begin
            bs_q   <= blk_start;
            ie_q   <= info_end;
            win_q  <= active;
            data_q <= dec_data;
        end
    end

    assign wr_o   = win_q;
    assign data_o = data_q;

    // position counter
    logic [CH_W-1:0]  ch_q, cur_ch;
    logic [POS_W-1:0] sym_q, cur_sym;
    logic             run_q, running, last_ch, last_sym;

    assign cur_ch   = start ? '0 : ch_q;
    assign cur_sym  = start ? '0 : sym_q;
    assign running  = start | run_q;
    assign last_ch  = (cur_ch == CH_W'(NCH - 1));
    assign last_sym = (cur_sym == POS_W'(N - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ch_q  <= '0;
            sym_q <= '0;
            run_q <= 1'b0;
        end else if (running) begin
            if (last_ch) begin
                ch_q <= '0;
                if (last_sym) begin
                    sym_q <= cur_sym;
                    run_q <= 1'b0;
                end else begin
                    sym_q <= cur_sym + POS_W'(1);
                    run_q <= 1'b1;
                end
            end else begin
                ch_q  <= cur_ch + CH_W'(1);
                sym_q <= cur_sym;
                run_q <= 1'b1;
            end
        end
    end

    // position store
    pos_entry_t        mem [POS_DEPTH];
    logic [FILL_W-1:0] fill_q, base_fill;
    logic              ovf_q, hit;

    assign base_fill = start ? '0 : fill_q;
    assign hit       = running & sym_corrected(dec_raw, dec_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q <= '0;
            ovf_q  <= 1'b0;
            for (int i = 0; i < int'(POS_DEPTH); i++) mem[i] <= '0;
        end else begin
            fill_q <= base_fill;
            ovf_q  <= start ? 1'b0 : ovf_q;
            if (hit) begin
                if (base_fill < FILL_W'(POS_DEPTH)) begin
                    mem[base_fill[RD_W-1:0]] <= '{ch: cur_ch, sym: cur_sym};
                    fill_q <= base_fill + FILL_W'(1);
                end else begin
                    ovf_q <= 1'b1;
                end
            end
        end
    end

    assign rd_entry = mem[rd_idx];
    assign fill_o   = fill_q;
    assign ovf_o    = ovf_q;

    AST_WR_OPEN: assert property (@(posedge clk) disable iff (rst)
        blk_start |=> wr_o); // R2
    AST_WR_CLOSE: assert property (@(posedge clk) disable iff (rst)
        ($past(info_end) && !info_end && !blk_start) |=> !wr_o); // R3
    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
        fill_q <= FILL_W'(POS_DEPTH)); // R10
    AST_OVF_FULL: assert property (@(posedge clk) disable iff (rst)
        ovf_q |-> (fill_q == FILL_W'(POS_DEPTH))); // R10
    AST_SYM_RANGE: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (sym_q <= POS_W'(N - 1))); // R9

endmodule

// File: rtl/rs_mon_stats.sv
module rs_mon_stats
    import rs_mon_pkg::*;
#(
    parameter int unsigned NDEC  = 2,
    parameter int unsigned ACC_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NDEC*ERR_W-1:0]  err_cnt,
    input  logic [NDEC-1:0]        err_found,
    input  logic [NDEC-1:0]        dec_fail,
    input  logic                   irq_clr,
    output logic [NDEC*ERR_W-1:0]  cnt_o,
    output logic [ACC_W-1:0]       total_o,
    output logic                   irq_o
);

    localparam int SUM_W = ERR_W + $clog2(NDEC + 1);
    localparam int WW    = ACC_W + 1;

    logic any_found, any_fail;
    assign any_found = |err_found;
    assign any_fail  = |dec_fail;

    logic [ERR_W-1:0] cnt_q [NDEC];

    for (genvar d = 0; d < int'(NDEC); d++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst) cnt_q[d] <= '0;
            else if (any_found && !dec_fail[d]) cnt_q[d] <= err_cnt[d*ERR_W +: ERR_W];
        end
        assign cnt_o[d*ERR_W +: ERR_W] = cnt_q[d];

        AST_FAIL_FREEZE: assert property (@(posedge clk) disable iff (rst)
            dec_fail[d] |=> $stable(cnt_q[d])); // R5
    end

    logic [SUM_W-1:0] sum;
    always_comb begin
        sum = '0;
        for (int d = 0; d < int'(NDEC); d++)
            if (err_found[d] && !dec_fail[d])
                sum = sum + SUM_W'(err_cnt[d*ERR_W +: ERR_W]);
    end

    logic [ACC_W-1:0] total_q;
    logic [WW-1:0]    wide;
    assign wide = {1'b0, total_q} + WW'(sum);

    logic irq_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            total_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            total_q <= wide[ACC_W] ? '1 : wide[ACC_W-1:0];
            if (any_fail)     irq_q <= 1'b1;
            else if (irq_clr) irq_q <= 1'b0;
        end
    end

    assign total_o = total_q;
    assign irq_o   = irq_q;

    AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
        any_fail |=> irq_o); // R7
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !irq_clr) |=> irq_o); // R7
    AST_TOTAL_MONO: assert property (@(posedge clk) disable iff (rst)
        any_found |=> (total_o >= $past(total_o))); // R6

endmodule

// File: rtl/rs_err_monitor.sv
module rs_err_monitor
    import rs_mon_pkg::*;
#(
    parameter int unsigned NDEC      = 2,
    parameter int unsigned NCH       = 2,
    parameter int unsigned N         = 255,
    parameter int unsigned POS_DEPTH = 16,
    parameter int unsigned ACC_W     = 16
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [NDEC-1:0]                       blk_start,
    input  logic [NDEC-1:0]                       info_end,
    input  logic [NDEC*SYM_W-1:0]                 dec_data,
    input  logic [NDEC*SYM_W-1:0]                 dec_raw,
    input  logic [NDEC*ERR_W-1:0]                 err_cnt,
    input  logic [NDEC-1:0]                       err_found,
    input  logic [NDEC-1:0]                       dec_fail,
    input  logic                                  irq_clr,
    input  logic [(NDEC > 1 ? $clog2(NDEC) : 1)-1:0] rd_dec,
    input  logic [$clog2(POS_DEPTH)-1:0]          rd_idx,
    output logic [NDEC-1:0]                       fifo_wr,
    output logic [NDEC*SYM_W-1:0]                 fifo_data,
    output logic [NDEC*ERR_W-1:0]                 cnt_stat,
    output logic [ACC_W-1:0]                      total_corr,
    output logic                                  fail_irq,
    output logic [ENTRY_W-1:0]                    rd_entry,
    output logic [$clog2(POS_DEPTH+1)-1:0]        rd_fill,
    output logic                                  rd_ovf
);

    localparam int FILL_W = $clog2(POS_DEPTH + 1);

    pos_entry_t        lane_entry [NDEC];
    logic [FILL_W-1:0] lane_fill  [NDEC];
    logic              lane_ovf   [NDEC];

    for (genvar d = 0; d < int'(NDEC); d++) begin : g_lane
        rs_mon_lane #(
            .NCH       (NCH),
            .N         (N),
            .POS_DEPTH (POS_DEPTH)
        ) u_lane (
            .clk       (clk),
            .rst       (rst),
            .blk_start (blk_start[d]),
            .info_end  (info_end[d]),
            .dec_data  (dec_data[d*SYM_W +: SYM_W]),
            .dec_raw   (dec_raw[d*SYM_W +: SYM_W]),
            .rd_idx    (rd_idx),
            .wr_o      (fifo_wr[d]),
            .data_o    (fifo_data[d*SYM_W +: SYM_W]),
            .rd_entry  (lane_entry[d]),
            .fill_o    (lane_fill[d]),
            .ovf_o     (lane_ovf[d])
        );
    end

    always_comb begin
        rd_entry = '0;
        rd_fill  = '0;
        rd_ovf   = 1'b0;
        for (int d = 0; d < int'(NDEC); d++) begin
            if (int'(rd_dec) == d) begin
                rd_entry = lane_entry[d];
                rd_fill  = lane_fill[d];
                rd_ovf   = lane_ovf[d];
            end
        end
    end

    rs_mon_stats #(
        .NDEC  (NDEC),
        .ACC_W (ACC_W)
    ) u_stats (
        .clk       (clk),
        .rst       (rst),
        .err_cnt   (err_cnt),
        .err_found (err_found),
        .dec_fail  (dec_fail),
        .irq_clr   (irq_clr),
        .cnt_o     (cnt_stat),
        .total_o   (total_corr),
        .irq_o     (fail_irq)
    );

endmodule

// File: tb/rs_err_monitor_bench.sv
module rs_err_monitor_bench;

    localparam int NDEC = 2;
    localparam int NCH  = 2;
    localparam int N    = 255;
    localparam int K    = 239;
    localparam int ACC  = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  blk_start, info_end, err_found, dec_fail, fifo_wr;
    logic [15:0] dec_data, dec_raw, fifo_data;
    logic [9:0]  err_cnt, cnt_stat;
    logic        irq_clr, fail_irq, rd_ovf;
    logic [0:0]  rd_dec;
    logic [3:0]  rd_idx;
    logic [ACC-1:0] total_corr;
    logic [11:0] rd_entry;
    logic [4:0]  rd_fill;

    always #4 clk = ~clk;

    rs_err_monitor #(.NDEC(NDEC), .NCH(NCH), .N(N), .POS_DEPTH(16), .ACC_W(ACC)) u_rs_err_monitor (
        .clk(clk), .rst(rst), .blk_start(blk_start), .info_end(info_end),
        .dec_data(dec_data), .dec_raw(dec_raw), .err_cnt(err_cnt),
        .err_found(err_found), .dec_fail(dec_fail), .irq_clr(irq_clr),
        .rd_dec(rd_dec), .rd_idx(rd_idx), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
        .cnt_stat(cnt_stat), .total_corr(total_corr), .fail_irq(fail_irq),
        .rd_entry(rd_entry), .rd_fill(rd_fill), .rd_ovf(rd_ovf)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [7:0] q0[$];
    logic [7:0] q1[$];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: pops expected information symbols as writes appear
    always @(posedge clk) begin
        #2;
        if (!rst && !done) begin
            if (fifo_wr[0]) begin
                if (q0.size() == 0) chk("R3 extra write dec0", 1, 0);
                else chk("R2 data dec0", {24'd0, fifo_data[7:0]}, {24'd0, q0.pop_front()});
            end
            if (fifo_wr[1]) begin
                if (q1.size() == 0) chk("R3 extra write dec1", 1, 0);
                else chk("R2 data dec1", {24'd0, fifo_data[15:8]}, {24'd0, q1.pop_front()});
            end
        end
    end

    function automatic bit is_err(int b, int d, int ch, int sym);
        if (b == 0 && d == 0)
            return (ch == 0 && sym == 0) || (ch == 1 && sym == 0) ||
                   (ch == 1 && sym == 100) || (ch == 0 && sym == 254);
        if (b == 1 && d == 1)
            return (ch == 0 && sym >= 10 && sym <= 18) || (ch == 1 && sym >= 10 && sym <= 17);
        if (b == 3 && d == 0)
            return ch == 1 && sym == 5;
        return 0;
    endfunction

    task automatic drive_block(input int b);
        for (int c = 0; c < N*NCH; c++) begin
            @(negedge clk);
            for (int d = 0; d < NDEC; d++) begin
                logic [7:0] v;
                v = 8'(b*37 + d*91 + c*3);
                dec_data[d*8 +: 8] = v;
                dec_raw[d*8 +: 8]  = is_err(b, d, c % NCH, c / NCH) ? (v ^ 8'h5A) : v;
                blk_start[d] = (c < NCH);
                info_end[d]  = (c >= (K-1)*NCH) && (c < K*NCH);
                if (c < K*NCH) begin
                    if (d == 0) q0.push_back(v); else q1.push_back(v);
                end
            end
            if (c == 0 || c == K*NCH-1 || c == K*NCH) begin
                @(posedge clk); #2;
                if (c == K*NCH) chk("R3 window closed after info_end", {30'd0, fifo_wr}, 32'd0);
                else chk("R2 window open", {30'd0, fifo_wr}, 32'd3);
            end
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        blk_start = '0; info_end = '0; dec_data = '0; dec_raw = '0;
        repeat (n) @(posedge clk);
    endtask

    task automatic rd_chk(input int d, input int idx, input int ch, input int sym, input string tag);
        @(negedge clk);
        rd_dec = 1'(d); rd_idx = 4'(idx);
        #1;
        chk(tag, {20'd0, rd_entry}, {20'd0, 4'(ch), 8'(sym)});
    endtask

    task automatic fill_chk(input int d, input int fill, input bit ovf, input string tag);
        @(negedge clk);
        rd_dec = 1'(d);
        #1;
        chk(tag, {27'd0, rd_fill}, 32'(fill));
        chk(tag, {31'd0, rd_ovf}, {31'd0, ovf});
    endtask

    // status model
    logic [4:0]     m_cnt [2] = '{5'd0, 5'd0};
    logic [ACC-1:0] m_total = '0;
    logic           m_irq = 1'b0;

    task automatic stat_step(input bit f0, input bit f1, input int c0, input int c1,
                             input bit fl0, input bit fl1, input bit clr, input string tag);
        int add, t;
        @(negedge clk);
        err_found = {f1, f0}; dec_fail = {fl1, fl0}; irq_clr = clr;
        err_cnt = {5'(c1), 5'(c0)};
        if (f0 || f1) begin
            if (!fl0) m_cnt[0] = 5'(c0);
            if (!fl1) m_cnt[1] = 5'(c1);
        end
        add = ((f0 && !fl0) ? c0 : 0) + ((f1 && !fl1) ? c1 : 0);
        t = int'(m_total) + add;
        m_total = (t > (1 << ACC) - 1) ? '1 : ACC'(t);
        if (fl0 || fl1) m_irq = 1'b1; else if (clr) m_irq = 1'b0;
        @(posedge clk); #2;
        chk({tag, " cnt"}, {22'd0, cnt_stat}, {22'd0, m_cnt[1], m_cnt[0]});
        chk({tag, " total"}, {24'd0, total_corr}, {24'd0, m_total});
        chk({tag, " irq"}, {31'd0, fail_irq}, {31'd0, m_irq});
        @(negedge clk);
        err_found = '0; dec_fail = '0; irq_clr = 1'b0; err_cnt = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        blk_start = '0; info_end = '0; dec_data = '0; dec_raw = '0;
        err_cnt = '0; err_found = '0; dec_fail = '0; irq_clr = 1'b0;
        rd_dec = '0; rd_idx = '0;
        repeat (4) @(posedge clk);
        #2;
        // R1 reset state
        chk("R1 fifo_wr", {30'd0, fifo_wr}, 0);
        chk("R1 fifo_data", {16'd0, fifo_data}, 0);
        chk("R1 cnt_stat", {22'd0, cnt_stat}, 0);
        chk("R1 total", {24'd0, total_corr}, 0);
        chk("R1 irq", {31'd0, fail_irq}, 0);
        chk("R1 fill", {27'd0, rd_fill}, 0);
        @(negedge clk) rst = 1'b0;

        // block 0: four differences on decoder 0, including a check symbol (R8)
        drive_block(0);
        idle(3);
        fill_chk(0, 4, 0, "R8 dec0 fill");
        fill_chk(1, 0, 0, "R8 dec1 no differences");
        rd_chk(0, 0, 0, 0,   "R8 entry0");
        rd_chk(0, 1, 1, 0,   "R9 entry1 channel");
        rd_chk(0, 2, 1, 100, "R9 entry2 position");
        rd_chk(0, 3, 0, 254, "R8 entry3 check symbol");

        // block 1: seventeen differences on decoder 1 (R10)
        drive_block(1);
        idle(3);
        fill_chk(1, 16, 1, "R10 dec1 overflow");
        fill_chk(0, 0, 0, "R10 dec0 cleared at new block");
        rd_chk(1, 0, 0, 10,  "R10 first kept");
        rd_chk(1, 7, 1, 13,  "R10 middle kept");
        rd_chk(1, 15, 1, 17, "R10 last kept");

        // back-to-back blocks, counter restarts on the second (R9)
        drive_block(2);
        drive_block(3);
        idle(3);
        fill_chk(0, 1, 0, "R9 back-to-back fill");
        rd_chk(0, 0, 1, 5, "R9 back-to-back restart");
        chk("R3 all info symbols written dec0", q0.size(), 0);
        chk("R3 all info symbols written dec1", q1.size(), 0);

        // status path
        stat_step(0, 0, 7, 9, 0, 0, 0, "R4 no found holds");
        stat_step(1, 0, 3, 0, 0, 0, 0, "R4 latch one");
        stat_step(1, 1, 5, 7, 0, 0, 0, "R6 latch both");
        stat_step(1, 1, 2, 9, 0, 1, 0, "R5 failing decoder frozen");
        stat_step(0, 0, 0, 0, 0, 0, 0, "R7 sticky");
        stat_step(0, 0, 0, 0, 0, 0, 1, "R7 cleared");
        stat_step(0, 0, 0, 0, 1, 0, 1, "R7 fail beats clear");
        for (int i = 0; i < 16; i++) stat_step(1, 1, 8, 8, 0, 0, 0, "R6 saturate");
        chk("R6 saturated value", {24'd0, total_corr}, 32'd255);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule